// File: doc/BRIEF.md
# Host Port Initialization Controller

This block holds the host-side control register of a byte-wide host port and carries out the self-clearing initialization command that the host can issue through it. The host writes one 8-bit word that holds two request-enable bits, two general-purpose host flags, a two-bit transfer mode and a command bit that starts initialization. The mode field selects either interrupt-driven transfers or a DMA transfer of 24, 16 or 8 bits.

When the host writes the register with the command bit set, the block runs the initialization in the next cycle. It drives one-cycle strobes that set or clear the transfer-status flags of the two data directions. It preloads the DMA byte address counter. It then clears the command bit without help from the host. The data registers and the host bus address decoding are outside this block. They consume the strobes and the counter value.

Top module: `hi_init_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets `ctrl_q` to 8'h00 and `byte_addr` to 0, and holds every strobe and `init_err` low.
- R2: A write (`wr_en` high at a rising edge) stores `wr_data` into `ctrl_q`. The bit positions are: bit 0 receive-request enable (RQR), bit 1 transmit-request enable (RQT), bit 3 host flag 0, bit 4 host flag 1, bits 6:5 mode, bit 7 INIT. Bit 2 is reserved and always reads 0, whatever is written to it.
- R3: `dma_on` is high exactly when the mode field `ctrl_q[6:5]` is not 00. The codes are 00 interrupt mode, 01 24-bit DMA, 10 16-bit DMA and 11 8-bit DMA.
- R4: After a write with INIT = 1, `ctrl_q[7]` reads 1 for one cycle and then 0, while the other bits keep the written value (unless the host writes again).
- R5: While INIT is stored and RQR = 1 (and the combination is legal), `rxdf_clr` and `htde_set` are high.
- R6: While INIT is stored and RQT = 1 (and the combination is legal), `txde_set` and `hrdf_clr` are high.
- R7: In interrupt mode, RQR = RQT = 1 with INIT gives all four strobes together.
- R8: In a DMA mode, RQR = RQT = 1 with INIT is illegal. `init_err` pulses for one cycle and no strobe fires.
- R9: On the edge that clears INIT, `byte_addr` is loaded with 0 in interrupt mode and with the mode code in a DMA mode.
- R10: Every strobe and `init_err` is high for exactly one cycle per INIT write, in the cycle after the write, and never without INIT.
- R11: A write with INIT = 0 leaves `byte_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the control register |
| wr_data | input | 8 | Host write data |
| ctrl_q | output | 8 | Current control register contents |
| dma_on | output | 1 | Mode field selects a DMA mode |
| rxdf_clr | output | 1 | Clear strobe for the DSP-to-host receive-full flag |
| htde_set | output | 1 | Set strobe for the DSP-side transmit-empty flag |
| txde_set | output | 1 | Set strobe for the host transmit-empty flag |
| hrdf_clr | output | 1 | Clear strobe for the DSP-side receive-full flag |
| init_err | output | 1 | One-cycle pulse for an illegal request pair in DMA mode |
| byte_addr | output | 2 | DMA byte address counter |

## Verification
The one-cycle strobe and self-clear properties assume that the host does not write again in the cycle right after an INIT write. Both properties are therefore qualified on `wr_en` being low in the observed cycle. The stimulus writes every one of the 256 possible control words, and it always leaves an idle cycle between writes, so it keeps within that assumption. Because each write is followed by an idle cycle, both the strobe cycle and the cleared-INIT cycle can be checked. The expected counter value carries over from the previous word, so the hold behaviour (R11) is checked against a bench model of the counter history.

// File: rtl/hi_init_pkg.sv
package hi_init_pkg;
  localparam int CTRL_W = 8;
  localparam int CNT_W  = 2;

  localparam int B_RQR  = 0;
  localparam int B_RQT  = 1;
  localparam int B_RSV  = 2;
  localparam int B_HF0  = 3;
  localparam int B_HF1  = 4;
  localparam int B_MLO  = 5;
  localparam int B_MHI  = 6;
  localparam int B_INIT = 7;

  typedef enum logic [1:0] {
    MODE_IRQ   = 2'b00,
    MODE_DMA24 = 2'b01,
    MODE_DMA16 = 2'b10,
    MODE_DMA8  = 2'b11
  } hi_mode_e;

  function automatic logic mode_is_dma(input logic [1:0] m);
    return hi_mode_e'(m) != MODE_IRQ;
  endfunction

  function automatic logic [CNT_W-1:0] preload_value(input logic [1:0] m);
    return mode_is_dma(m) ? CNT_W'(m) : '0;
  endfunction

  function automatic logic [CTRL_W-1:0] mask_reserved(input logic [CTRL_W-1:0] v);
    logic [CTRL_W-1:0] r;
    r = v;
    r[B_RSV] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/hi_ctrl_reg.sv
module hi_ctrl_reg
  import hi_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              init_done,
  output logic [CTRL_W-1:0] ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl <= mask_reserved(wr_data);
    end else if (init_done) begin
      ctrl[B_INIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/hi_init_exec.sv
module hi_init_exec
  import hi_init_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  output logic              fire,
  output logic              dma,
  output logic              rxdf_clr,
  output logic              htde_set,
  output logic              txde_set,
  output logic              hrdf_clr,
  output logic              illegal
);
  logic rqr, rqt, bad_pair;

  always_comb begin
    fire     = ctrl[B_INIT];
    dma      = mode_is_dma(ctrl[B_MHI:B_MLO]);
    rqr      = ctrl[B_RQR];
    rqt      = ctrl[B_RQT];
    bad_pair = dma && rqr && rqt;
    illegal  = fire && bad_pair;
    rxdf_clr = fire && rqr && !bad_pair;
    htde_set = fire && rqr && !bad_pair;
    txde_set = fire && rqt && !bad_pair;
    hrdf_clr = fire && rqt && !bad_pair;
  end
endmodule

// File: rtl/hi_addr_cnt.sv
module hi_addr_cnt
  import hi_init_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [1:0]       mode,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= preload_value(mode);
    end
  end
endmodule

// File: rtl/hi_init_ctrl.sv
module hi_init_ctrl
  import hi_init_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              dma_on,
  output logic              rxdf_clr,
  output logic              htde_set,
  output logic              txde_set,
  output logic              hrdf_clr,
  output logic              init_err,
  output logic [CNT_W-1:0]  byte_addr
);
  logic              init_fire;
  logic [CTRL_W-1:0] ctrl;

  hi_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .init_done(init_fire), .ctrl(ctrl)
  );

  hi_init_exec u_exec (
    .ctrl(ctrl), .fire(init_fire), .dma(dma_on),
    .rxdf_clr(rxdf_clr), .htde_set(htde_set),
    .txde_set(txde_set), .hrdf_clr(hrdf_clr), .illegal(init_err)
  );

  hi_addr_cnt u_cnt (
    .clk(clk), .rst(rst), .load(init_fire),
    .mode(ctrl[B_MHI:B_MLO]), .cnt(byte_addr)
  );

  assign ctrl_q = ctrl;
endmodule

// File: rtl/hi_init_ctrl_chk.sv
module hi_init_ctrl_chk
  import hi_init_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              rxdf_clr,
  input logic              htde_set,
  input logic              txde_set,
  input logic              hrdf_clr,
  input logic              init_err,
  input logic [CNT_W-1:0]  byte_addr
);
  logic any_strobe;
  assign any_strobe = rxdf_clr || htde_set || txde_set || hrdf_clr || init_err;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0 && byte_addr == '0));

  a_r4_init_self_clear: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[B_INIT] && !wr_en) |=> !ctrl_q[B_INIT]);

  a_r8_illegal_no_strobe: assert property (@(posedge clk) disable iff (rst)
    init_err |-> !(rxdf_clr || htde_set || txde_set || hrdf_clr));

  a_r9_preload: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[B_INIT] && !wr_en) |=> byte_addr == $past(ctrl_q[B_MHI:B_MLO]));

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (any_strobe && !wr_en) |=> !any_strobe);

  a_r10_needs_init: assert property (@(posedge clk) disable iff (rst)
    any_strobe |-> ctrl_q[B_INIT]);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[B_INIT] |=> $stable(byte_addr));
endmodule

bind hi_init_ctrl hi_init_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .ctrl_q(ctrl_q),
  .rxdf_clr(rxdf_clr), .htde_set(htde_set), .txde_set(txde_set),
  .hrdf_clr(hrdf_clr), .init_err(init_err), .byte_addr(byte_addr)
);

// File: tb/sim_hi_init_ctrl.sv
module sim_hi_init_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl_q;
  logic       dma_on, rxdf_clr, htde_set, txde_set, hrdf_clr, init_err;
  logic [1:0] byte_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hi_init_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .dma_on(dma_on), .rxdf_clr(rxdf_clr),
    .htde_set(htde_set), .txde_set(txde_set), .hrdf_clr(hrdf_clr),
    .init_err(init_err), .byte_addr(byte_addr)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [1:0] addr_model;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 ctrl", ctrl_q, 8'h00);
    check("R1 addr", {6'd0, byte_addr}, 8'h00);
    check("R1 strobes", {3'd0, rxdf_clr, htde_set, txde_set, hrdf_clr, init_err}, 8'h00);
    rst = 1'b0;
    addr_model = 2'd0;
    // exhaustive sweep over every control word
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      logic       dma, fire, ill, rq, tq;
      e    = 8'(v) & 8'hFB;
      dma  = (e[6:5] != 2'b00);
      fire = e[7];
      rq   = e[0];
      tq   = e[1];
      ill  = dma && rq && tq;
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 8'(v);
      @(negedge clk);
      wr_en = 1'b0;
      #0.5;
      check("R2 store", ctrl_q, e);
      check("R3 dma_on", {7'd0, dma_on}, {7'd0, dma});
      // R5 R6 R7 R8 strobe cycle
      check("R5 rxdf_clr", {7'd0, rxdf_clr}, {7'd0, fire && rq && !ill});
      check("R5 htde_set", {7'd0, htde_set}, {7'd0, fire && rq && !ill});
      check("R6 txde_set", {7'd0, txde_set}, {7'd0, fire && tq && !ill});
      check("R6 hrdf_clr", {7'd0, hrdf_clr}, {7'd0, fire && tq && !ill});
      if (!dma && rq && tq && fire)
        check("R7 all four", {4'd0, rxdf_clr, htde_set, txde_set, hrdf_clr}, 8'h0F);
      check("R8 init_err", {7'd0, init_err}, {7'd0, fire && ill});
      @(negedge clk);
      #0.5;
      if (fire) addr_model = dma ? e[6:5] : 2'd0;
      check("R4 self clear", ctrl_q, e & 8'h7F);
      check(fire ? "R9 preload" : "R11 hold", {6'd0, byte_addr}, {6'd0, addr_model});
      check("R10 one cycle", {3'd0, rxdf_clr, htde_set, txde_set, hrdf_clr, init_err}, 8'h00);
    end
    // R1: reset in mid-run clears a loaded counter
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 8'hE0;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R9 dma8 preload", {6'd0, byte_addr}, 8'h03);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again ctrl", ctrl_q, 8'h00);
    check("R1 reset again addr", {6'd0, byte_addr}, 8'h00);
    rst = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule